// File: doc/BRIEF.md
# Write Completion Status Poller

This block sits in the read path of a byte-alterable nonvolatile memory model. While the write controller reports that an internal programming cycle is running, reads do not return array contents. They return a status word instead. Software polls that word to learn when programming has finished, so no interrupt line is needed.

Two status bits are provided. The top bit returns the complement of the top bit of the byte that was loaded last. The bit below it inverts on every new read access. When programming ends, the top bit matches the stored value again and the second bit stops changing. While the memory is idle, reads pass the array data through unchanged.

The block is clocked. The chip-select and output-select strobes are sampled on the clock edge, and the returned word is registered. Driving a shared bus (tri-state timing) is left to the surrounding logic.

Top module: `poll_status_top`

## Requirements
- R1: While reset is active, and on the first sample after it, `rd_en` is 0 and `rd_data` is all zeros.
- R2: `rd_en` is 1 in the cycle after a clock edge at which `ce_n` and `oe_n` are both 0. After an edge at which either one is 1, `rd_en` is 0 and `rd_data` is all zeros.
- R3: When `prog_busy` is 0 at the edge, an enabled read returns the `arr_rdata` value sampled at that edge. It follows array changes on every cycle of the access.
- R4: When `prog_busy` is 1 at the edge, bit 7 of an enabled read is the inverse of bit 7 of the last loaded byte, whatever the array holds.
- R5: When `prog_busy` is 1 at the edge, bits 5 to 0 of an enabled read equal bits 5 to 0 of the last loaded byte, for any array value.
- R6: While busy, bit 6 inverts at the start of each new access. An access starts when the select goes from inactive to active at an edge where `prog_busy` is 1. Bit 6 then holds for the rest of that access. Its first value is unspecified.
- R7: When idle, all eight bits, including bits 7 and 6, are true array data. Idle accesses do not advance the toggle, so the next busy access shows the inverse of bit 6 from the previous busy access.
- R8: The last loaded byte is replaced only at edges where `wr_load` is 1. A write refused by protection produces neither a load pulse nor busy, so the status keeps the earlier byte. A load made during busy is reflected from the next read cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output select, active low |
| wr_load | input | 1 | Pulse from the write controller when a byte is accepted |
| wr_byte | input | 8 | Byte accepted with `wr_load` |
| prog_busy | input | 1 | Internal programming cycle in progress |
| arr_rdata | input | 8 | Array data at the current read address |
| rd_data | output | 8 | Registered read word (array data or status) |
| rd_en | output | 1 | Read word valid (memory selected for reading) |

## Verification
The hardest case to reach from the ports is bit 6 continuing its alternation across unrelated events. These include idle reads between two programming cycles, a byte load that arrives during busy, and accesses opened only by chip select while output select stays low. Bit 6 has no defined starting value, so the bench adopts the first value it sees and then predicts every later one. The stimulus runs two separate busy periods with idle reads between them, inserts a page-style load and a refused write inside busy, and varies which strobe opens each access. A broken toggle therefore shows up as a wrong prediction rather than going unnoticed.

// File: rtl/poll_pkg.sv
package poll_pkg;
  // status bit positions, counted down from the top of the data word
  localparam int FLAG_FROM_TOP   = 1;
  localparam int TOGGLE_FROM_TOP = 2;

  // both active-low strobes asserted means a read is requested
  function automatic logic bus_selected(input logic ce_n, input logic oe_n);
    return ~ce_n & ~oe_n;
  endfunction
endpackage

// File: rtl/poll_access_detect.sv
module poll_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic sel,
  output logic acc_start
);
  logic sel_q;

  assign sel = poll_pkg::bus_selected(ce_n, oe_n);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel;
  end

  // an access begins where the combined select becomes active
  assign acc_start = sel & ~sel_q;
endmodule

// File: rtl/poll_last_byte.sv
module poll_last_byte #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tog_q,
  output logic tog_nxt
);
  assign tog_nxt = tog_q ^ adv;

  always_ff @(posedge clk) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_nxt;
  end
endmodule

// File: rtl/poll_status_top.sv
module poll_status_top #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          wr_load,
  input  logic [DW-1:0] wr_byte,
  input  logic          prog_busy,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_en
);
  localparam int FLAG_BIT   = DW - poll_pkg::FLAG_FROM_TOP;
  localparam int TOGGLE_BIT = DW - poll_pkg::TOGGLE_FROM_TOP;

  // named internal events, also observed by the bound checker
  logic          sel;
  logic          acc_start;
  logic          tog_adv;
  logic          tog_q;
  logic          tog_nxt;
  logic [DW-1:0] last_q;
  logic [DW-1:0] status_w;
  logic [DW-1:0] word_d;

  function automatic logic [DW-1:0] poll_word(input logic [DW-1:0] lb,
                                              input logic          t);
    logic [DW-1:0] w;
    w             = lb;
    w[FLAG_BIT]   = ~lb[FLAG_BIT];
    w[TOGGLE_BIT] = t;
    return w;
  endfunction

  poll_access_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .sel       (sel),
    .acc_start (acc_start)
  );

  poll_last_byte #(.DW(DW)) u_last (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_load),
    .din   (wr_byte),
    .q     (last_q)
  );

  assign tog_adv = acc_start & prog_busy;

  poll_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (tog_adv),
    .tog_q   (tog_q),
    .tog_nxt (tog_nxt)
  );

  assign status_w = poll_word(last_q, tog_nxt);

  always_comb begin
    if (!sel)          word_d = '0;
    else if (prog_busy) word_d = status_w;
    else               word_d = arr_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_en   <= sel;
      rd_data <= word_d;
    end
  end
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          wr_load,
  input logic          prog_busy,
  input logic [DW-1:0] arr_rdata,
  input logic [DW-1:0] rd_data,
  input logic          rd_en,
  input logic [DW-1:0] last_q,
  input logic          tog_q,
  input logic          acc_start
);
  p_sel_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |=> rd_en);

  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> (!rd_en && rd_data == '0));

  p_idle_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !prog_busy) |=> rd_data == $past(arr_rdata));

  p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && prog_busy) |=> rd_data[DW-1] != $past(last_q[DW-1]));

  p_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && prog_busy) |=> rd_data[DW-3:0] == $past(last_q[DW-3:0]));

  p_tog_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && prog_busy) |=> tog_q != $past(tog_q));

  p_idle_no_tog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_busy |=> tog_q == $past(tog_q));

  p_last_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load |=> $stable(last_q));
endmodule

bind poll_status_top poll_status_chk #(.DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .wr_load   (wr_load),
  .prog_busy (prog_busy),
  .arr_rdata (arr_rdata),
  .rd_data   (rd_data),
  .rd_en     (rd_en),
  .last_q    (last_q),
  .tog_q     (tog_q),
  .acc_start (acc_start)
);

// File: tb/test_poll_status_top.sv
module test_poll_status_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, oe_n, wr_load, prog_busy;
  logic [7:0] wr_byte, arr_rdata;
  logic [7:0] rd_data;
  logic       rd_en;

  int errs   = 0;
  int checks = 0;

  // behavioural reference state
  logic [7:0] m_last     = 8'h00;
  bit         m_prev_sel = 1'b0;
  bit         m_shown    = 1'b0;
  bit         m_known    = 1'b0;

  always #10 clk = ~clk;

  poll_status_top i_poll_status_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .wr_load(wr_load), .wr_byte(wr_byte), .prog_busy(prog_busy),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .rd_en(rd_en)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply one cycle of inputs, predict, then compare after the edge
  task automatic step(input bit ce, input bit oe, input bit wl,
                      input logic [7:0] wb, input bit busy,
                      input logic [7:0] arr, input string tag);
    bit         sel;
    bit         chk6;
    logic [7:0] e;
    ce_n = ce; oe_n = oe; wr_load = wl; wr_byte = wb;
    prog_busy = busy; arr_rdata = arr;
    sel  = !ce && !oe;
    chk6 = 1'b0;
    if (!sel) e = 8'h00;
    else if (!busy) e = arr;
    else begin
      e    = {~m_last[7], 1'b0, m_last[5:0]};
      chk6 = 1'b1;
      if (!m_prev_sel) m_shown = ~m_shown;
    end
    m_prev_sel = sel;
    if (wl) m_last = wb;
    @(posedge clk);
    @(negedge clk);
    check(rd_en === sel, "R2", {7'd0, rd_en}, {7'd0, sel});
    if (chk6) begin
      check((rd_data & 8'hBF) === e, tag, rd_data & 8'hBF, e);
      if (m_known) check(rd_data[6] === m_shown, "R6", {7'd0, rd_data[6]}, {7'd0, m_shown});
      else begin m_known = 1'b1; m_shown = rd_data[6]; end
    end else begin
      check(rd_data === e, tag, rd_data, e);
    end
  endtask

  task automatic access(input int n, input bit busy, input logic [7:0] arr,
                        input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, busy, arr + 8'(i * 37), tag);
    step(1, 1, 0, 8'h00, busy, arr, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; wr_load = 1'b0;
    wr_byte = 8'h00; prog_busy = 1'b0; arr_rdata = 8'hE7;
    repeat (3) @(negedge clk);
    check(rd_en === 1'b0, "R1", {7'd0, rd_en}, 8'h00);
    check(rd_data === 8'h00, "R1", rd_data, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    rst_n = 1'b1;
    step(1, 1, 0, 8'h00, 0, 8'hAA, "R1");
    // single strobes are not a read
    step(0, 1, 0, 8'h00, 0, 8'hAA, "R2");
    step(1, 0, 0, 8'h00, 0, 8'hAA, "R2");
    step(1, 0, 0, 8'h00, 1, 8'h55, "R2");
    // idle pass-through, array changing within access
    access(3, 0, 8'h00, "R3");
    access(2, 0, 8'hFF, "R3");
    access(4, 0, 8'h5A, "R3");
    access(1, 0, 8'h80, "R7");
    access(1, 0, 8'h40, "R7");
    // first programming cycle, last byte 3C
    step(1, 1, 1, 8'h3C, 0, 8'h00, "R8");
    access(2, 1, 8'h00, "R4");
    access(2, 1, 8'hFF, "R5");
    access(6, 1, 8'h81, "R6");
    // accesses opened by chip select only
    step(1, 0, 0, 8'h00, 1, 8'h00, "R2");
    step(0, 0, 0, 8'h00, 1, 8'h12, "R6");
    step(1, 0, 0, 8'h00, 1, 8'h00, "R2");
    step(0, 0, 0, 8'h00, 1, 8'h34, "R6");
    // refused write: no load pulse, status keeps 3C
    step(1, 1, 0, 8'h91, 1, 8'h00, "R8");
    access(2, 1, 8'h77, "R8");
    // page-style load during busy
    step(1, 1, 1, 8'hC5, 1, 8'h00, "R8");
    access(3, 1, 8'h3C, "R4");
    // programming done: true data, no toggle
    access(2, 0, 8'h3C, "R7");
    access(2, 0, 8'hC5, "R7");
    access(3, 0, 8'h6B, "R3");
    step(1, 1, 0, 8'h22, 0, 8'h00, "R8");
    access(1, 0, 8'h00, "R7");
    // second programming cycle with new byte, alternation continues
    step(1, 1, 1, 8'h2A, 0, 8'h00, "R8");
    access(1, 1, 8'hD4, "R4");
    access(2, 1, 8'h01, "R5");
    access(1, 1, 8'hFE, "R6");
    access(1, 1, 8'h10, "R6");
    access(2, 0, 8'h2A, "R3");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule